// File: doc/BRIEF.md
# Configurable Multi-Function I/O Port

This block manages one bidirectional port of `PORT_W` pins. Each pin can take one of several roles, chosen by four configuration registers written through a small register interface. As a general-purpose pin, a value register and a direction register set what it drives and whether it drives. As an address pin, it shows one bit of the latched address byte in place of the value register. When the whole port is switched to peripheral mode, it becomes an extension of the processor data bus. In that mode it is gated by two select lines, and a read strobe or a write strobe sets which way data flows.

The output driver of each pin is also controlled by an external per-pin enable term. This lets decode logic elsewhere drive a pin even when software has left it as an input. The address-out control can work per pin, or per nibble when the `SPLIT_NIBBLE` variant is chosen.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the value, direction, control and mode registers all read 0, `dbus_oe` is 0 and `pad_oe` equals `ext_oe`, so every pin is an input unless an external enable drives it.
- R2: When peripheral mode is off, `pad_oe[i]` is the OR of direction bit i and `ext_oe[i]`.
- R3: When peripheral mode is off and a pin's address control is 0, `pad_o[i]` carries bit i of the value register.
- R4: When peripheral mode is off and a pin's address control is 1, `pad_o[i]` carries `lat_addr[i]`.
- R5: With `SPLIT_NIBBLE`=1, control bit 0 selects address output for pins 3..0 and control bit 1 does so for pins 7..4. The remaining control bits have no effect on the pins.
- R6: Peripheral mode is on only while bit `PIO_BIT` (default 7) of the mode register is 1. The other mode bits have no effect on the pins or on the data bus.
- R7: In peripheral mode, with `psel0` or `psel1` high and `rd_stb` high, every pin is driven and `pad_o` equals `dbus_in`.
- R8: In peripheral mode, with a select high, `wr_stb` high and `rd_stb` low, `dbus_oe` is 1, `dbus_out` equals `pad_i` and no pin is driven.
- R9: In peripheral mode, when both selects are low or both strobes are low, `pad_oe` is all zero and `dbus_oe` is 0, whatever the value of `ext_oe`.
- R10: In peripheral mode, when both strobes are high with a select high, the read direction wins: all pins are driven and `dbus_oe` is 0.
- R11: Reading register offset 0 returns the value register bit for pins whose direction bit is 1, and the live `pad_i` bit for pins whose direction bit is 0.
- R12: The register offsets are 0 for value, 1 for direction, 2 for control and 3 for mode. A write takes effect on the next rising clock edge. Reading offsets 1 to 3 returns the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | PORT_W | Register write data |
| reg_rdata | output | PORT_W | Register read data (combinational) |
| lat_addr | input | PORT_W | Latched address byte |
| ext_oe | input | PORT_W | External per-pin output enable |
| psel0 | input | 1 | Peripheral select 0 |
| psel1 | input | 1 | Peripheral select 1 |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| dbus_in | input | PORT_W | Processor data bus, into the port |
| dbus_out | output | PORT_W | Data driven toward the processor bus |
| dbus_oe | output | 1 | Enable for `dbus_out` |
| pad_i | input | PORT_W | Pin input levels |
| pad_o | output | PORT_W | Pin output values |
| pad_oe | output | PORT_W | Pin output-driver enables |

## Verification
The bench builds the block with `PORT_W`=8, `SPLIT_NIBBLE`=1 and `PIO_BIT`=7. With these values, each nibble can be switched to the address byte on its own while the other nibble keeps register data, and the upper control bits can be shown to have no effect. With a byte-wide port, the peripheral-mode bit sits at the top of the mode register, so writing every other mode bit set is a real test that those bits are ignored.

// File: rtl/cfg_io_port_pkg.sv
package cfg_io_port_pkg;
   typedef enum logic [1:0] {
      OFS_VALUE = 2'd0,
      OFS_DIR   = 2'd1,
      OFS_CTL   = 2'd2,
      OFS_MODE  = 2'd3
   } cfg_ofs_e;

   localparam int unsigned NIBBLE_W = 4;
endpackage

// File: rtl/cfg_io_port_regs.sv
module cfg_io_port_regs
   import cfg_io_port_pkg::*;
#(
   parameter int unsigned PORT_W  = 8,
   parameter int unsigned PIO_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        ofs,
   input  logic [PORT_W-1:0] wdata,
   input  logic [PORT_W-1:0] pad_i,
   output logic [PORT_W-1:0] value_q,
   output logic [PORT_W-1:0] dir_q,
   output logic [PORT_W-1:0] ctl_q,
   output logic              pio_en,
   output logic [PORT_W-1:0] rdata
);
   logic [PORT_W-1:0] mode_q;
   cfg_ofs_e          sel;

   assign sel = cfg_ofs_e'(ofs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
         dir_q   <= '0;
         ctl_q   <= '0;
         mode_q  <= '0;
      end else if (we) begin
         unique case (sel)
            OFS_VALUE: value_q <= wdata;
            OFS_DIR:   dir_q   <= wdata;
            OFS_CTL:   ctl_q   <= wdata;
            OFS_MODE:  mode_q  <= wdata;
         endcase
      end
   end

   assign pio_en = mode_q[PIO_BIT];

   always_comb begin
      unique case (sel)
         OFS_VALUE: rdata = (value_q & dir_q) | (pad_i & ~dir_q);
         OFS_DIR:   rdata = dir_q;
         OFS_CTL:   rdata = ctl_q;
         OFS_MODE:  rdata = mode_q;
      endcase
   end
endmodule

// File: rtl/cfg_io_port_pinmux.sv
module cfg_io_port_pinmux
   import cfg_io_port_pkg::*;
#(
   parameter int unsigned PORT_W       = 8,
   parameter bit          SPLIT_NIBBLE = 1'b1,
   localparam int unsigned GRP_W       = SPLIT_NIBBLE ? NIBBLE_W : 1,
   localparam int unsigned N_GRP       = PORT_W / GRP_W
) (
   input  logic [N_GRP-1:0]  ctl,
   input  logic [PORT_W-1:0] dir,
   input  logic [PORT_W-1:0] value,
   input  logic [PORT_W-1:0] ext_oe,
   input  logic [PORT_W-1:0] lat_addr,
   output logic [PORT_W-1:0] mcu_o,
   output logic [PORT_W-1:0] mcu_oe
);
   logic [PORT_W-1:0] addr_sel;

   generate
      if (SPLIT_NIBBLE) begin : g_nibble
         for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            assign addr_sel[g*GRP_W +: GRP_W] = {GRP_W{ctl[g]}};
         end
      end else begin : g_pin
         assign addr_sel = ctl;
      end
   endgenerate

   generate
      for (genvar i = 0; i < PORT_W; i++) begin : g_bit
         assign mcu_o[i]  = addr_sel[i] ? lat_addr[i] : value[i];
         assign mcu_oe[i] = dir[i] | ext_oe[i];
      end
   endgenerate
endmodule

// File: rtl/cfg_io_port_pio.sv
module cfg_io_port_pio #(
   parameter int unsigned PORT_W = 8
) (
   input  logic              en,
   input  logic              psel0,
   input  logic              psel1,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [PORT_W-1:0] dbus_in,
   input  logic [PORT_W-1:0] pad_i,
   output logic [PORT_W-1:0] pio_o,
   output logic [PORT_W-1:0] pio_oe,
   output logic [PORT_W-1:0] dbus_out,
   output logic              dbus_oe
);
   logic sel_any;
   logic to_pins;
   logic to_bus;

   assign sel_any = psel0 | psel1;
   assign to_pins = en & sel_any & rd_stb;
   assign to_bus  = en & sel_any & wr_stb & ~rd_stb;

   assign pio_o    = dbus_in;
   assign pio_oe   = {PORT_W{to_pins}};
   assign dbus_out = to_bus ? pad_i : '0;
   assign dbus_oe  = to_bus;
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
   import cfg_io_port_pkg::*;
#(
   parameter int unsigned PORT_W       = 8,
   parameter bit          SPLIT_NIBBLE = 1'b1,
   parameter int unsigned PIO_BIT      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [PORT_W-1:0] reg_wdata,
   output logic [PORT_W-1:0] reg_rdata,
   input  logic [PORT_W-1:0] lat_addr,
   input  logic [PORT_W-1:0] ext_oe,
   input  logic              psel0,
   input  logic              psel1,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [PORT_W-1:0] dbus_in,
   output logic [PORT_W-1:0] dbus_out,
   output logic              dbus_oe,
   input  logic [PORT_W-1:0] pad_i,
   output logic [PORT_W-1:0] pad_o,
   output logic [PORT_W-1:0] pad_oe
);
   localparam int unsigned GRP_W = SPLIT_NIBBLE ? NIBBLE_W : 1;
   localparam int unsigned N_GRP = PORT_W / GRP_W;

   generate
      if (PORT_W < 2) begin : g_bad_width
         $error("cfg_io_port: PORT_W must be at least 2");
      end
      if (PIO_BIT >= PORT_W) begin : g_bad_pio
         $error("cfg_io_port: PIO_BIT must lie inside the mode register");
      end
      if (SPLIT_NIBBLE && (PORT_W % NIBBLE_W != 0)) begin : g_bad_split
         $error("cfg_io_port: nibble split needs PORT_W divisible by 4");
      end
   endgenerate

   logic [PORT_W-1:0] value_q, dir_q, ctl_q;
   logic              pio_en;
   logic [PORT_W-1:0] mcu_o, mcu_oe, pio_o, pio_oe;

   cfg_io_port_regs #(.PORT_W(PORT_W), .PIO_BIT(PIO_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .ofs(reg_addr),
      .wdata(reg_wdata), .pad_i(pad_i),
      .value_q(value_q), .dir_q(dir_q), .ctl_q(ctl_q),
      .pio_en(pio_en), .rdata(reg_rdata)
   );

   cfg_io_port_pinmux #(.PORT_W(PORT_W), .SPLIT_NIBBLE(SPLIT_NIBBLE)) u_pinmux (
      .ctl(ctl_q[N_GRP-1:0]), .dir(dir_q), .value(value_q),
      .ext_oe(ext_oe), .lat_addr(lat_addr),
      .mcu_o(mcu_o), .mcu_oe(mcu_oe)
   );

   cfg_io_port_pio #(.PORT_W(PORT_W)) u_pio (
      .en(pio_en), .psel0(psel0), .psel1(psel1),
      .rd_stb(rd_stb), .wr_stb(wr_stb),
      .dbus_in(dbus_in), .pad_i(pad_i),
      .pio_o(pio_o), .pio_oe(pio_oe),
      .dbus_out(dbus_out), .dbus_oe(dbus_oe)
   );

   assign pad_o  = pio_en ? pio_o  : mcu_o;
   assign pad_oe = pio_en ? pio_oe : mcu_oe;
endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk #(
   parameter int unsigned PORT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pio_en,
   input logic              reg_we,
   input logic [1:0]        reg_addr,
   input logic [PORT_W-1:0] reg_wdata,
   input logic              psel0,
   input logic              psel1,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic [PORT_W-1:0] dbus_in,
   input logic [PORT_W-1:0] dbus_out,
   input logic              dbus_oe,
   input logic [PORT_W-1:0] pad_i,
   input logic [PORT_W-1:0] pad_o,
   input logic [PORT_W-1:0] pad_oe
);
   // R2: a direction write outside peripheral mode enables those drivers next cycle
   p_dir_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd1 && !pio_en)
      |=> ((pad_oe & $past(reg_wdata)) == $past(reg_wdata)));

   // R7: selected read pushes the data bus onto every pin
   p_pio_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_en && (psel0 || psel1) && rd_stb)
      |-> (pad_oe == '1 && pad_o == dbus_in));

   // R8: selected write alone returns pin levels on the data bus
   p_pio_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_en && (psel0 || psel1) && wr_stb && !rd_stb)
      |-> (dbus_oe && dbus_out == pad_i && pad_oe == '0));

   // R9: no select means nothing is driven in peripheral mode
   p_pio_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_en && !psel0 && !psel1) |-> (pad_oe == '0 && !dbus_oe));

   // R10: both directions are never driven at once
   p_one_way_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pio_en |-> !(dbus_oe && (pad_oe != '0)));
endmodule

bind cfg_io_port cfg_io_port_chk #(.PORT_W(PORT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pio_en(pio_en),
   .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .psel0(psel0), .psel1(psel1), .rd_stb(rd_stb), .wr_stb(wr_stb),
   .dbus_in(dbus_in), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
   .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
);

// File: tb/cfg_io_port_bench.sv
module cfg_io_port_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [1:0]   reg_addr = 2'd0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic [W-1:0] lat_addr = '0;
   logic [W-1:0] ext_oe = '0;
   logic         psel0 = 1'b0, psel1 = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic [W-1:0] dbus_in = '0;
   logic [W-1:0] dbus_out;
   logic         dbus_oe;
   logic [W-1:0] pad_i = '0;
   logic [W-1:0] pad_o, pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cfg_io_port #(.PORT_W(W), .SPLIT_NIBBLE(1'b1), .PIO_BIT(7)) u_cfg_io_port (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lat_addr(lat_addr),
      .ext_oe(ext_oe), .psel0(psel0), .psel1(psel1), .rd_stb(rd_stb),
      .wr_stb(wr_stb), .dbus_in(dbus_in), .dbus_out(dbus_out),
      .dbus_oe(dbus_oe), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
   );

   // fields: dir, ctl, value, ext_oe, lat_addr, pad_i, exp_oe, exp_o, exp_rd
   localparam logic [71:0] VECS [6] = '{
      {8'hFF, 8'h00, 8'h3C, 8'h00, 8'h5A, 8'h00, 8'hFF, 8'h3C, 8'h3C},
      {8'h0F, 8'h00, 8'hA5, 8'h30, 8'h00, 8'hC3, 8'h3F, 8'hA5, 8'hC5},
      {8'hFF, 8'h01, 8'h00, 8'h00, 8'h96, 8'h00, 8'hFF, 8'h06, 8'h00},
      {8'hFF, 8'h02, 8'hFF, 8'h00, 8'h96, 8'h00, 8'hFF, 8'h9F, 8'hFF},
      {8'h00, 8'hFC, 8'h12, 8'h81, 8'hE7, 8'h7E, 8'h81, 8'h12, 8'h7E},
      {8'hF0, 8'h03, 8'h00, 8'h0F, 8'hE7, 8'h55, 8'hFF, 8'hE7, 8'h05}
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] ofs, input logic [W-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = ofs; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] ofs, input string req, input logic [W-1:0] exp);
      reg_addr = ofs;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic strobes(input logic s0, input logic s1, input logic r, input logic w);
      psel0 = s0; psel1 = s1; rd_stb = r; wr_stb = w;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      ext_oe = 8'h24; pad_i = 8'hA5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_reg(2'd1, "R1 dir", 8'h00);
      rd_reg(2'd2, "R1 ctl", 8'h00);
      rd_reg(2'd3, "R1 mode", 8'h00);
      rd_reg(2'd0, "R1 value reads pins", 8'hA5);
      chk("R1 pad_oe", pad_oe, 8'h24);
      chk("R1 dbus_oe", {7'd0, dbus_oe}, 8'h00);

      // R2 R3 R4 R5 R11: vector table
      for (int v = 0; v < 6; v++) begin
         logic [71:0] t;
         t = VECS[v];
         wr_reg(2'd1, t[71:64]);
         wr_reg(2'd2, t[63:56]);
         wr_reg(2'd0, t[55:48]);
         ext_oe = t[47:40]; lat_addr = t[39:32]; pad_i = t[31:24];
         #1;
         chk($sformatf("R2 vec%0d pad_oe", v), pad_oe, t[23:16]);
         chk($sformatf("R3/R4/R5 vec%0d pad_o", v), pad_o, t[15:8]);
         rd_reg(2'd0, $sformatf("R11 vec%0d readback", v), t[7:0]);
      end

      // R12: control readback after vector 5 left 03, then new value
      wr_reg(2'd2, 8'h5A);
      rd_reg(2'd2, "R12 ctl", 8'h5A);
      wr_reg(2'd1, 8'h00);
      rd_reg(2'd1, "R12 dir", 8'h00);
      wr_reg(2'd2, 8'h00);
      wr_reg(2'd0, 8'h00);

      // R6: all mode bits except bit 7 leave peripheral mode off
      wr_reg(2'd3, 8'h7F);
      rd_reg(2'd3, "R12 mode", 8'h7F);
      ext_oe = 8'h00; dbus_in = 8'h11; pad_i = 8'h66;
      strobes(1, 0, 1, 0);
      chk("R6 pio off pad_oe", pad_oe, 8'h00);
      chk("R6 pio off pad_o", pad_o, 8'h00);
      strobes(1, 0, 0, 1);
      chk("R6 pio off dbus_oe", {7'd0, dbus_oe}, 8'h00);
      strobes(0, 0, 0, 0);

      // peripheral mode on
      wr_reg(2'd3, 8'h80);
      ext_oe = 8'hFF;
      strobes(0, 0, 1, 0);
      chk("R9 no select pad_oe", pad_oe, 8'h00);
      chk("R9 no select dbus_oe", {7'd0, dbus_oe}, 8'h00);
      dbus_in = 8'hC9;
      strobes(1, 0, 1, 0);
      chk("R7 read pad_oe", pad_oe, 8'hFF);
      chk("R7 read pad_o", pad_o, 8'hC9);
      pad_i = 8'h3E;
      strobes(0, 1, 0, 1);
      chk("R8 write dbus_oe", {7'd0, dbus_oe}, 8'h01);
      chk("R8 write dbus_out", dbus_out, 8'h3E);
      chk("R8 write pad_oe", pad_oe, 8'h00);
      strobes(1, 0, 1, 1);
      chk("R10 both pad_oe", pad_oe, 8'hFF);
      chk("R10 both dbus_oe", {7'd0, dbus_oe}, 8'h00);
      strobes(1, 1, 0, 0);
      chk("R9 no strobe pad_oe", pad_oe, 8'h00);
      chk("R9 no strobe dbus_oe", {7'd0, dbus_oe}, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule